// File: doc/BRIEF.md
# Pipelined Bus Subordinate with Wait States

This block is a subordinate endpoint on an AHB-Lite style system bus that fronts a small word-organised register array. A manager issues an address phase lasting one clock. The block samples the address and control in that cycle. The data phase that follows completes the write or the read, and fixed read and write wait-state counts, set by parameters, may stretch it. Any access whose byte address falls past the end of the array is refused with a two-cycle error response and has no effect on storage.

Address and data phases overlap. The cycle that completes one transfer's data phase can also carry the next transfer's address phase, so back-to-back transfers run without idle cycles. Writes honour byte and halfword sizes by updating only the addressed byte lanes.

Top module: `ahb_wait_slave`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to its idle state. After that edge `readyout_o` is 1, `resp_o` is 0 (OKAY), `rdata_o` is 0 and every stored byte is 0.
- R2: An address phase is taken only when `sel_i` is 1, `trans_i` is 2 (NONSEQ) or 3 (SEQ), and `ready_i` is 1, all at the same edge. With `sel_i` low, or `trans_i` at 0 (IDLE) or 1 (BUSY), nothing is stored and the next cycle shows `readyout_o`=1 and `resp_o`=0.
- R3: A taken in-range read holds `readyout_o` low for exactly `RD_WAIT` data-phase cycles. It then shows `readyout_o`=1 and `resp_o`=0, with the addressed word on `rdata_o`. Outside that final cycle `rdata_o` is 0.
- R4: A taken in-range write holds `readyout_o` low for exactly `WR_WAIT` data-phase cycles. It stores `wdata_i` as sampled in the final data-phase cycle, when `readyout_o` is 1.
- R5: `size_i` selects the write width: 0 is a byte, 1 is a halfword, and 2 or more is a full word. Byte lane n is `wdata_i[8n+7:8n]`. A byte write updates lane `addr_i[1:0]`. A halfword write updates lanes 0-1 if `addr_i[1]` is 0 and lanes 2-3 otherwise. Lanes not selected keep their value.
- R6: A taken access with `addr_i` >= 4*`MEM_WORDS` gets an error with no wait states. The first data-phase cycle shows `readyout_o`=0 and `resp_o`=1. The second shows `readyout_o`=1 and `resp_o`=1. Storage is unchanged.
- R7: A new address phase is accepted in the final data-phase cycle of the previous transfer. A read of the word that an immediately preceding write updates returns the new data.
- R8: `resp_o` is 1 with `readyout_o` at 1 only in the cycle right after a cycle with `resp_o`=1 and `readyout_o`=0. Every wait-state cycle shows `resp_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 1 | Subordinate select from the address decoder |
| addr_i | input | ADDR_W | Byte address (address phase) |
| write_i | input | 1 | 1 = write, 0 = read (address phase) |
| size_i | input | 3 | Transfer size code (address phase) |
| trans_i | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| wdata_i | input | 32 | Write data (data phase) |
| ready_i | input | 1 | Bus-wide ready; previous transfer is finishing |
| rdata_o | output | 32 | Read data, valid in the final read data cycle |
| readyout_o | output | 1 | Low to insert a wait state |
| resp_o | output | 1 | 0 = OKAY, 1 = ERROR |

## Verification
Two things can fall in the same cycle: the final data-phase cycle of one transfer and the address phase of the next. The bench provokes this by placing a read address phase in the completing cycle of a write to the same word, while still holding the write data on `wdata_i`. It judges the result by the read's wait count and by the returned word, which must equal the freshly written value rather than the old contents. The second overlap case issues an address phase in the second error cycle. That case is judged by the following transfer completing normally.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam logic [1:0] TR_IDLE   = 2'd0;
    localparam logic [1:0] TR_BUSY   = 2'd1;
    localparam logic [1:0] TR_NONSEQ = 2'd2;
    localparam logic [1:0] TR_SEQ    = 2'd3;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_ERR_LO,
        PH_ERR_HI
    } phase_e;

    typedef struct packed {
        logic       is_write;
        logic [2:0] size;
        logic [1:0] lane;
    } xfer_ctrl_t;

    // byte lanes touched by a write of the given size at the given offset
    function automatic logic [LANES-1:0] lane_strobe(input logic [2:0] size,
                                                     input logic [1:0] lane);
        logic [LANES-1:0] s;
        case (size)
            3'd0:    s = LANES'(1) << lane;
            3'd1:    s = lane[1] ? LANES'(4'b1100) : LANES'(4'b0011);
            default: s = '1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ahbw_addr_stage.sv
module ahbw_addr_stage
    import ahbw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] idx_d,
    input  xfer_ctrl_t       ctrl_d,
    output logic [IDX_W-1:0] idx_q,
    output xfer_ctrl_t       ctrl_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ctrl_q <= '0;
        end else if (take) begin
            idx_q  <= idx_d;
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/ahbw_phase_ctrl.sv
module ahbw_phase_ctrl
    import ahbw_pkg::*;
#(
    parameter int RD_WAIT = 2,
    parameter int WR_WAIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic hit,
    input  logic is_write,
    output logic readyout,
    output logic resp,
    output logic complete
);

    localparam int MAXW  = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int CNT_W = $clog2(MAXW + 2);

    phase_e           ph;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else if (take) begin
            if (hit) begin
                ph  <= PH_DATA;
                cnt <= is_write ? CNT_W'(WR_WAIT) : CNT_W'(RD_WAIT);
            end else begin
                ph  <= PH_ERR_LO;
                cnt <= '0;
            end
        end else begin
            case (ph)
                PH_DATA: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else           ph  <= PH_IDLE;
                end
                PH_ERR_LO: ph <= PH_ERR_HI;
                PH_ERR_HI: ph <= PH_IDLE;
                default:   ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        complete = (ph == PH_DATA) && (cnt == '0);
        readyout = !(((ph == PH_DATA) && (cnt != '0)) || (ph == PH_ERR_LO));
        resp     = (ph == PH_ERR_LO) || (ph == PH_ERR_HI);
    end

endmodule

// File: rtl/ahbw_store.sv
module ahbw_store
    import ahbw_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  strobe,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WORDS; w++) lane_mem[w] <= '0;
            end else if (we && strobe[b]) begin
                lane_mem[idx] <= wdata[8*b +: 8];
            end
        end

        assign rdata[8*b +: 8] = lane_mem[idx];
    end

endmodule

// File: rtl/ahb_wait_slave.sv
module ahb_wait_slave
    import ahbw_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int MEM_WORDS = 16,
    parameter int RD_WAIT   = 2,
    parameter int WR_WAIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  logic [2:0]        size_i,
    input  logic [1:0]        trans_i,
    input  logic [31:0]       wdata_i,
    input  logic              ready_i,
    output logic [31:0]       rdata_o,
    output logic              readyout_o,
    output logic              resp_o
);

    localparam int IDX_W = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_WORDS * 4);

    logic             take;
    logic             hit;
    xfer_ctrl_t       ctrl_d;
    xfer_ctrl_t       ctrl_q;
    logic [IDX_W-1:0] idx_q;
    logic             complete;
    logic [31:0]      store_rd;

    always_comb begin
        take            = sel_i && trans_i[1] && ready_i;
        hit             = {1'b0, addr_i} < LIMIT;
        ctrl_d.is_write = write_i;
        ctrl_d.size     = size_i;
        ctrl_d.lane     = addr_i[1:0];
    end

    ahbw_addr_stage #(.IDX_W(IDX_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .idx_d  (addr_i[IDX_W+1:2]),
        .ctrl_d (ctrl_d),
        .idx_q  (idx_q),
        .ctrl_q (ctrl_q)
    );

    ahbw_phase_ctrl #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .hit      (hit),
        .is_write (write_i),
        .readyout (readyout_o),
        .resp     (resp_o),
        .complete (complete)
    );

    ahbw_store #(.WORDS(MEM_WORDS), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (complete && ctrl_q.is_write),
        .idx    (idx_q),
        .strobe (lane_strobe(ctrl_q.size, ctrl_q.lane)),
        .wdata  (wdata_i),
        .rdata  (store_rd)
    );

    assign rdata_o = (complete && !ctrl_q.is_write) ? store_rd : '0;

endmodule

// File: rtl/ahbw_checker.sv
module ahbw_checker #(
    parameter int ADDR_W    = 8,
    parameter int MEM_WORDS = 16,
    parameter int RD_WAIT   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic [1:0]        trans_i,
    input logic              write_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ready_i,
    input logic              readyout_o,
    input logic              resp_o
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_WORDS * 4);

    logic take_c;
    assign take_c = sel_i && trans_i[1] && ready_i;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (readyout_o && !resp_o));

    assert_no_take_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_c && readyout_o && !resp_o) |=> (readyout_o && !resp_o));

    if (RD_WAIT > 0) begin : g_rdwait
        assert_read_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (take_c && !write_i && ({1'b0, addr_i} < LIMIT)) |=> (!readyout_o && !resp_o));
    end

    assert_error_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o && !readyout_o) |=> (resp_o && readyout_o));

    assert_error_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_c && !({1'b0, addr_i} < LIMIT)) |=> (resp_o && !readyout_o));

    assert_err_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o && readyout_o) |-> $past(resp_o && !readyout_o));

endmodule

bind ahb_wait_slave ahbw_checker #(
    .ADDR_W    (ADDR_W),
    .MEM_WORDS (MEM_WORDS),
    .RD_WAIT   (RD_WAIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .trans_i    (trans_i),
    .write_i    (write_i),
    .addr_i     (addr_i),
    .ready_i    (ready_i),
    .readyout_o (readyout_o),
    .resp_o     (resp_o)
);

// File: tb/tb_ahb_wait_slave.sv
`timescale 1ns/1ps
module tb_ahb_wait_slave;

    localparam int RDW = 2;
    localparam int WRW = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic [7:0]  addr = '0;
    logic        write = 1'b0;
    logic [2:0]  size = 3'd2;
    logic [1:0]  trans = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        readyout;
    logic        resp;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ahb_wait_slave #(.ADDR_W(8), .MEM_WORDS(16), .RD_WAIT(RDW), .WR_WAIT(WRW)) dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .addr_i(addr), .write_i(write),
        .size_i(size), .trans_i(trans), .wdata_i(wdata), .ready_i(readyout),
        .rdata_o(rdata), .readyout_o(readyout), .resp_o(resp)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  sz;
        logic [7:0]  ad;
        logic [31:0] wd;
        logic [31:0] rd;
        logic        err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd2, 8'h00, 32'h11223344, 32'h0,        1'b0},  // R4 word write
        '{1'b0, 3'd2, 8'h00, 32'h0,        32'h11223344, 1'b0},  // R3 read back
        '{1'b1, 3'd0, 8'h05, 32'h0000AB00, 32'h0,        1'b0},  // R5 byte lane 1
        '{1'b1, 3'd1, 8'h06, 32'hCDEF0000, 32'h0,        1'b0},  // R5 upper half
        '{1'b0, 3'd2, 8'h04, 32'h0,        32'hCDEFAB00, 1'b0},  // R5 merged word
        '{1'b1, 3'd2, 8'h3C, 32'hDEADBEEF, 32'h0,        1'b0},  // last word
        '{1'b0, 3'd2, 8'h3C, 32'h0,        32'hDEADBEEF, 1'b0},
        '{1'b1, 3'd2, 8'h40, 32'hFFFFFFFF, 32'h0,        1'b1},  // R6 first bad
        '{1'b0, 3'd2, 8'h80, 32'h0,        32'h0,        1'b1},  // R6 far bad
        '{1'b0, 3'd2, 8'h00, 32'h0,        32'h11223344, 1'b0},  // R6 unchanged
        '{1'b1, 3'd0, 8'h03, 32'h99000000, 32'h0,        1'b0},  // R5 lane 3
        '{1'b0, 3'd2, 8'h00, 32'h0,        32'h99223344, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [2:0] sz, input logic [7:0] ad,
                        input logic [31:0] wd, input logic [31:0] exp_rd,
                        input logic exp_err, input string req);
        int waits;
        @(negedge clk);
        sel = 1'b1; trans = 2'd2; write = wr; size = sz; addr = ad;
        @(negedge clk);
        sel = 1'b0; trans = 2'd0; wdata = wd;
        waits = 0;
        while (!readyout && !resp && waits < 20) begin
            waits++;
            @(negedge clk);
        end
        if (exp_err) begin
            chk(resp && !readyout && waits == 0, {req, " err cycle1"},
                {30'd0, resp, readyout}, 32'h2);
            @(negedge clk);
            chk(resp && readyout, {req, " err cycle2"}, {30'd0, resp, readyout}, 32'h3);
        end else begin
            chk(!resp && waits == (wr ? WRW : RDW), {req, " waits"}, waits,
                wr ? WRW : RDW);
            if (!wr) chk(rdata == exp_rd, {req, " rdata"}, rdata, exp_rd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        chk(readyout && !resp && rdata == 0, "R1 reset outputs",
            {rdata[29:0], readyout, resp}, 32'h2);
        rst_n = 1'b1;
        xfer(1'b0, 3'd2, 8'h08, 32'h0, 32'h0, 1'b0, "R1 storage zero");

        for (int i = 0; i < NV; i++)
            xfer(VECS[i].wr, VECS[i].sz, VECS[i].ad, VECS[i].wd, VECS[i].rd,
                 VECS[i].err, "R3/R4/R5/R6 vector");

        // R2: deselected write, IDLE and BUSY writes ignored
        @(negedge clk);
        sel = 1'b0; trans = 2'd2; write = 1'b1; addr = 8'h00; size = 3'd2;
        @(negedge clk);
        wdata = 32'hFFFFFFFF;
        chk(readyout && !resp, "R2 sel low", {30'd0, readyout, resp}, 32'h2);
        sel = 1'b1; trans = 2'd0;
        @(negedge clk);
        chk(readyout && !resp, "R2 idle", {30'd0, readyout, resp}, 32'h2);
        trans = 2'd1;
        @(negedge clk);
        chk(readyout && !resp, "R2 busy", {30'd0, readyout, resp}, 32'h2);
        sel = 1'b0; trans = 2'd0;
        xfer(1'b0, 3'd2, 8'h00, 32'h0, 32'h99223344, 1'b0, "R2 storage kept");

        // R7: read address phase in the completing cycle of a write, same word
        @(negedge clk);
        sel = 1'b1; trans = 2'd2; write = 1'b1; size = 3'd2; addr = 8'h10;
        @(negedge clk);
        trans = 2'd0; sel = 1'b0; wdata = 32'hA5A55A5A;
        chk(!readyout, "R7 write wait", {31'd0, readyout}, 32'h0);
        @(negedge clk);
        chk(readyout && !resp, "R7 write done", {30'd0, readyout, resp}, 32'h2);
        sel = 1'b1; trans = 2'd2; write = 1'b0; addr = 8'h10;
        @(negedge clk);
        sel = 1'b0; trans = 2'd0; wdata = 32'h0;
        chk(!readyout && !resp, "R7 R8 read wait1", {30'd0, readyout, resp}, 32'h0);
        @(negedge clk);
        chk(!readyout && !resp, "R7 R8 read wait2", {30'd0, readyout, resp}, 32'h0);
        @(negedge clk);
        chk(readyout && rdata == 32'hA5A55A5A, "R7 overlap read", rdata, 32'hA5A55A5A);

        // R6/R7: address phase in the second error cycle
        @(negedge clk);
        sel = 1'b1; trans = 2'd2; write = 1'b0; addr = 8'hF0;
        @(negedge clk);
        sel = 1'b0; trans = 2'd0;
        chk(resp && !readyout, "R6 err1", {30'd0, resp, readyout}, 32'h2);
        @(negedge clk);
        chk(resp && readyout, "R8 err2", {30'd0, resp, readyout}, 32'h3);
        sel = 1'b1; trans = 2'd3; addr = 8'h04;
        @(negedge clk);
        sel = 1'b0; trans = 2'd0;
        @(negedge clk);
        @(negedge clk);
        chk(readyout && !resp && rdata == 32'hCDEFAB00, "R7 after error", rdata,
            32'hCDEFAB00);

        // R1: reset in the middle of a read data phase clears everything
        @(negedge clk);
        sel = 1'b1; trans = 2'd2; write = 1'b0; addr = 8'h00;
        @(negedge clk);
        sel = 1'b0; trans = 2'd0; rst_n = 1'b0;
        @(negedge clk);
        chk(readyout && !resp && rdata == 0, "R1 mid reset",
            {rdata[29:0], readyout, resp}, 32'h2);
        rst_n = 1'b1;
        xfer(1'b0, 3'd2, 8'h00, 32'h0, 32'h0, 1'b0, "R1 cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule